// File: doc/BRIEF.md
# Double-Buffered Bitplane Tile Frame Buffer

This block keeps two complete captured pictures in tile-pattern form and lets a tile-based picture processor fetch pattern bytes from one of them while a capture engine writes the next picture into the other. Each of the two banks contains two byte-wide memories that share one address bus. One memory holds bitplane 0 and the other holds bitplane 1, for every tile in the bank.

On the display side, the processor's pattern-fetch address is remapped. Bit 3 selects the bitplane and is removed from the memory address. The remaining fetch bits, together with the upper banked pattern-page bits, form the memory address. The capture side writes both bitplanes of one tile row in a single cycle, always into the bank that is not on display.

A swap request exchanges the roles of the two banks. The request takes effect only at a clock edge where the capture side reports vertical blank. A request made mid-frame is held until then. Read data reaches the processor's byte bus through per-memory output enables, which model tri-state drivers. When no fetch is in progress, the bus is released.

Top module: `fb_dual_bank`

## Requirements
- R1: After reset, `disp_bank` is 0, `rd_oe` is 0 and `rd_data` is 0. No swap is pending.
- R2: A fetch reads memory index {page_addr, fetch_addr[9:4], fetch_addr[2:0]} from the displayed bank. fetch_addr[3]=0 picks the bitplane-0 memory and fetch_addr[3]=1 picks the bitplane-1 memory.
- R3: When `fetch_en` is high at a clock edge, `rd_oe` is high in the following cycle and `rd_data` holds the addressed byte.
- R4: When `fetch_en` is low at a clock edge, `rd_oe` is low in the following cycle. Whenever `rd_oe` is low, `rd_data` reads as all zeros (the released bus).
- R5: When `cap_we` is high at a clock edge, `cap_plane0` is stored at `cap_addr` in the bitplane-0 memory and `cap_plane1` at `cap_addr` in the bitplane-1 memory, both in the bank not on display.
- R6: The displayed bank is never written.
- R7: A swap (toggle of `disp_bank`) happens only at an edge where `cap_vblank` is high and a request is present, either `swap_req` in that cycle or one held from earlier. A request seen while `cap_vblank` is low is held. Extra requests while one is held merge into it.
- R8: A fetch or capture write in the same cycle as an applied swap uses the bank roles from before the swap.
- R9: At most one of the four memories drives `rd_data` in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_en | input | 1 | Display side is fetching a pattern byte |
| fetch_addr | input | 10 | Display pattern-fetch address, bits 0 to 9 |
| page_addr | input | PAGE_W | Banked pattern-page bits above fetch bit 9 |
| cap_we | input | 1 | Capture write strobe |
| cap_addr | input | PAGE_W+9 | Capture memory index |
| cap_plane0 | input | 8 | Capture byte for bitplane 0 |
| cap_plane1 | input | 8 | Capture byte for bitplane 1 |
| swap_req | input | 1 | Request to exchange bank roles |
| cap_vblank | input | 1 | Capture side is in vertical blank |
| disp_bank | output | 1 | Index of the bank on display |
| rd_oe | output | 1 | Read data is being driven |
| rd_data | output | 8 | Pattern byte to the processor |

## Verification
Two functions can fall into the same cycle: a bank swap taking effect, and a display fetch or capture write. The bench provokes this by raising `swap_req` or `cap_vblank` in the cycle that also fetches and writes. These cycles occur both in a directed sequence and throughout a long randomized run.

A behavioural model with its own arrays per bank and plane applies each access with the bank roles as they stood before the edge. It compares the displayed bank, the output enable and the returned byte after every clock. A misplaced swap therefore shows up as a read from the wrong picture, or as a write that lands in the displayed bank.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int FETCH_W   = 10;
  localparam int PLANE_BIT = 3;
  localparam int ROW_W     = FETCH_W - 1;

  // Removes the bitplane bit and closes the gap in the fetch address.
  function automatic logic [ROW_W-1:0] row_index(input logic [FETCH_W-1:0] fa);
    return {fa[FETCH_W-1:PLANE_BIT+1], fa[PLANE_BIT-1:0]};
  endfunction

  function automatic logic plane_of(input logic [FETCH_W-1:0] fa);
    return fa[PLANE_BIT];
  endfunction
endpackage

// File: rtl/fb_swap_ctrl.sv
module fb_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic cap_vblank,
  output logic disp_bank,
  output logic swap_pend,
  output logic swap_evt
);
  assign swap_evt = cap_vblank && (swap_req || swap_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_bank <= 1'b0;
      swap_pend <= 1'b0;
    end else if (swap_evt) begin
      disp_bank <= ~disp_bank;
      swap_pend <= 1'b0;
    end else if (swap_req) begin
      swap_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/fb_addr_mux.sv
module fb_addr_mux #(
  parameter int AW = 10
) (
  input  logic          is_capture,
  input  logic [AW-1:0] disp_addr,
  input  logic          disp_ce,
  input  logic [AW-1:0] cap_addr,
  input  logic          cap_ce,
  output logic [AW-1:0] addr,
  output logic          ce,
  output logic          we
);
  always_comb begin
    if (is_capture) begin
      addr = cap_addr;
      ce   = cap_ce;
      we   = cap_ce;
    end else begin
      addr = disp_addr;
      ce   = disp_ce;
      we   = 1'b0;
    end
  end
endmodule

// File: rtl/fb_plane_ram.sv
module fb_plane_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ce && we) mem[addr] <= wdata;
    if (ce && !we) rdata <= mem[addr];
  end
endmodule

// File: rtl/fb_dual_bank.sv
module fb_dual_bank #(
  parameter int PAGE_W = 1,
  parameter int DW     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fetch_en,
  input  logic [fb_pkg::FETCH_W-1:0]      fetch_addr,
  input  logic [PAGE_W-1:0]               page_addr,
  input  logic                            cap_we,
  input  logic [PAGE_W+fb_pkg::ROW_W-1:0] cap_addr,
  input  logic [DW-1:0]                   cap_plane0,
  input  logic [DW-1:0]                   cap_plane1,
  input  logic                            swap_req,
  input  logic                            cap_vblank,
  output logic                            disp_bank,
  output logic                            rd_oe,
  output logic [DW-1:0]                   rd_data
);
  localparam int MEM_AW = PAGE_W + fb_pkg::ROW_W;
  localparam int NBANK  = 2;
  localparam int NPLANE = 2;
  localparam int NMEM   = NBANK * NPLANE;

  logic swap_pend, swap_evt;
  logic [MEM_AW-1:0] disp_addr;
  logic [MEM_AW-1:0] bank_addr [NBANK];
  logic [NBANK-1:0]  bank_ce, bank_we;
  logic [DW-1:0]     mem_q [NMEM];
  logic [NMEM-1:0]   drv_oe;
  logic              rd_bank_q, rd_plane_q, rd_oe_q;

  fb_swap_ctrl u_swap (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .cap_vblank(cap_vblank),
    .disp_bank(disp_bank), .swap_pend(swap_pend), .swap_evt(swap_evt)
  );

  assign disp_addr = {page_addr, fb_pkg::row_index(fetch_addr)};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    fb_addr_mux #(.AW(MEM_AW)) u_mux (
      .is_capture(disp_bank != 1'(b)),
      .disp_addr(disp_addr), .disp_ce(fetch_en),
      .cap_addr(cap_addr),   .cap_ce(cap_we),
      .addr(bank_addr[b]), .ce(bank_ce[b]), .we(bank_we[b])
    );
    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
      fb_plane_ram #(.AW(MEM_AW), .DW(DW)) u_ram (
        .clk(clk), .ce(bank_ce[b]), .we(bank_we[b]), .addr(bank_addr[b]),
        .wdata(p == 0 ? cap_plane0 : cap_plane1),
        .rdata(mem_q[b*NPLANE+p])
      );
      assign drv_oe[b*NPLANE+p] = rd_oe_q && (rd_bank_q == 1'(b)) && (rd_plane_q == 1'(p));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_oe_q    <= 1'b0;
      rd_bank_q  <= 1'b0;
      rd_plane_q <= 1'b0;
    end else begin
      rd_oe_q <= fetch_en;
      if (fetch_en) begin
        rd_bank_q  <= disp_bank;
        rd_plane_q <= fb_pkg::plane_of(fetch_addr);
      end
    end
  end

  // Wired-OR of gated drivers stands in for the tri-state bus.
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NMEM; k++)
      if (drv_oe[k]) rd_data = rd_data | mem_q[k];
  end

  assign rd_oe = rd_oe_q;
endmodule

// File: rtl/fb_dual_bank_chk.sv
module fb_dual_bank_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_en,
  input logic          swap_req,
  input logic          cap_vblank,
  input logic          swap_pend,
  input logic          disp_bank,
  input logic          rd_oe,
  input logic [DW-1:0] rd_data,
  input logic [3:0]    drv_oe,
  input logic [1:0]    bank_we
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drv_oe)); // R9
  AST_OE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n) fetch_en |=> rd_oe); // R3
  AST_OE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !fetch_en |=> !rd_oe); // R4
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !rd_oe |-> rd_data == '0); // R4
  AST_HOLD_OUTSIDE_VBLANK: assert property (@(posedge clk) disable iff (!rst_n) !cap_vblank |=> $stable(disp_bank)); // R7
  AST_SWAP_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n) (cap_vblank && (swap_req || swap_pend)) |=> disp_bank != $past(disp_bank)); // R7
  AST_DISPLAY_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n) bank_we[disp_bank] == 1'b0); // R6
endmodule

bind fb_dual_bank fb_dual_bank_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .swap_req(swap_req),
  .cap_vblank(cap_vblank), .swap_pend(swap_pend), .disp_bank(disp_bank),
  .rd_oe(rd_oe), .rd_data(rd_data), .drv_oe(drv_oe), .bank_we(bank_we)
);

// File: tb/test_fb_dual_bank.sv
module test_fb_dual_bank;
  localparam int PAGE_W = 1;
  localparam int AW     = PAGE_W + 9;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_en = 0, cap_we = 0, swap_req = 0, cap_vblank = 0;
  logic [9:0] fetch_addr = '0;
  logic [PAGE_W-1:0] page_addr = '0;
  logic [AW-1:0] cap_addr = '0;
  logic [7:0] cap_plane0 = '0, cap_plane1 = '0;
  logic disp_bank, rd_oe;
  logic [7:0] rd_data;

  fb_dual_bank #(.PAGE_W(PAGE_W)) i_fb_dual_bank (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
    .page_addr(page_addr), .cap_we(cap_we), .cap_addr(cap_addr),
    .cap_plane0(cap_plane0), .cap_plane1(cap_plane1), .swap_req(swap_req),
    .cap_vblank(cap_vblank), .disp_bank(disp_bank), .rd_oe(rd_oe), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model state
  logic [7:0] m_mem [2][2][DEPTH];
  int m_bank = 0;
  bit m_pend = 0;
  bit e_oe = 0;
  logic [7:0] e_data = '0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Inputs are already driven; predict the edge, wait for it, compare.
  task automatic step();
    int idx, pl;
    e_oe = fetch_en;
    if (fetch_en) begin
      idx = (int'(page_addr) << 9) | (int'(fetch_addr[9:4]) << 3) | int'(fetch_addr[2:0]);
      pl = int'(fetch_addr[3]);
      e_data = m_mem[m_bank][pl][idx];
    end else e_data = '0;
    if (cap_we) begin
      m_mem[1-m_bank][0][cap_addr] = cap_plane0;
      m_mem[1-m_bank][1][cap_addr] = cap_plane1;
    end
    if ((m_pend || swap_req) && cap_vblank) begin
      m_bank = 1 - m_bank;
      m_pend = 0;
    end else if (swap_req) m_pend = 1;
    @(posedge clk);
    @(negedge clk);
    check("R7 disp_bank", int'(disp_bank), m_bank);
    check("R3 R4 rd_oe", int'(rd_oe), int'(e_oe));
    check("R2 R3 R4 R5 R6 R8 R9 rd_data", int'(rd_data), int'(e_data));
  endtask

  task automatic idle_inputs();
    fetch_en = 0; cap_we = 0; swap_req = 0; cap_vblank = 0;
  endtask

  task automatic fill_capture(input int seed, input bit with_fetch);
    for (int a = 0; a < DEPTH; a++) begin
      cap_we = 1; cap_addr = AW'(a);
      cap_plane0 = 8'(a * 7 + seed);
      cap_plane1 = 8'(a * 13 + seed + 3);
      fetch_en = with_fetch;
      fetch_addr = 10'($urandom); page_addr = PAGE_W'($urandom);
      step();
    end
    idle_inputs();
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < DEPTH; a++) m_mem[b][p][a] = '0;
    repeat (3) @(negedge clk);
    check("R1 disp_bank", int'(disp_bank), 0);
    check("R1 rd_oe", int'(rd_oe), 0);
    check("R1 rd_data", int'(rd_data), 0);
    rst_n = 1;
    step();
    // Fill bank 1 (capture) without fetching.
    fill_capture(5, 1'b0);
    // Mid-frame request is held (R7).
    swap_req = 1; step(); swap_req = 0;
    repeat (4) step();
    check("R7 held request", int'(disp_bank), 0);
    cap_vblank = 1; step(); cap_vblank = 0;
    check("R7 applied in vblank", int'(disp_bank), 1);
    // Fill bank 0 while fetching every cycle from bank 1 (R5 R6).
    fill_capture(91, 1'b1);
    // Swap plus fetch plus write in one cycle (R8).
    fetch_en = 1; fetch_addr = 10'h2A8; page_addr = '1;
    cap_we = 1; cap_addr = AW'(17); cap_plane0 = 8'hC3; cap_plane1 = 8'h3C;
    swap_req = 1; cap_vblank = 1;
    step();
    idle_inputs();
    check("R8 swap same cycle", int'(disp_bank), 0);
    // Read back the location written in the swap cycle from both planes (R8 R2).
    fetch_en = 1; fetch_addr = {6'(17 >> 3), 1'b0, 3'(17)}; page_addr = '0; step();
    fetch_addr[3] = 1'b1; step();
    idle_inputs(); step();
    // Randomized mixed traffic.
    for (int i = 0; i < 4000; i++) begin
      fetch_en = 1'($urandom);
      fetch_addr = 10'($urandom); page_addr = PAGE_W'($urandom);
      cap_we = 1'($urandom); cap_addr = AW'($urandom);
      cap_plane0 = 8'($urandom); cap_plane1 = 8'($urandom);
      swap_req = ($urandom % 16) == 0;
      cap_vblank = ($urandom % 8) == 0;
      step();
    end
    idle_inputs(); step();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule